// File: doc/BRIEF.md
# Configuration Register File with Command Register

This block is a byte-wide configuration store that a host reaches through a simple request/response port, such as the one a serial-bus slave front end presents once it has decoded a transfer. The top address of the map is not storage. It is a command/status byte. One bit of it asks the upstream side to attach and at the same time locks the rest of the map against writes. A second bit restores every byte to its power-on value. A third bit shuts the access port down for good once the acknowledge of the current transfer has gone out.

Requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when all of these hold: the port is active, no response is outstanding and no soft reset is in progress. The host may hold `req_valid` and its fields for as long as it likes. They are sampled only on the accepting edge. Each accepted request produces exactly one response. That response stays valid, with stable data, until the host takes it with `rsp_ready`. This gives the host full back-pressure. The edge on which a response is taken is the acknowledge-complete event.

The power-on contents of the configuration bytes come from two parameters: `(DEF_BASE + index * DEF_STEP) mod 256`.

Top module: `cfg_regfile_cmd`

## Requirements
- R1: After `rst_n` is released, every byte at index 0 to 2^AW-2 reads `(DEF_BASE + index*DEF_STEP) mod 256`. In addition, the command byte reads 00h, `attach_req` is 0, `if_active` is 1, `req_ready` is 1 and `rsp_valid` is 0.
- R2: An accepted request raises `rsp_valid` on the next edge. While `rsp_ready` is 0, `rsp_valid` stays high and `rsp_rdata` stays unchanged, and `req_ready` stays low.
- R3: When the attach bit is 0, a write to any index from 0 to 2^AW-2 is stored, and a later read of that index returns it.
- R4: The command byte sits at the top address (all address bits set). It reads as {5'b0, power-down bit 2, soft-reset bit 1, attach bit 0}. Bits 7:3 read 0, and any value written to them is ignored.
- R5: Writing 1 to bit 0 of the command byte drives `attach_req` high and makes indices 0 to 2^AW-2 read-only. Writes to them are still acknowledged but change nothing, and reads return the stored data.
- R6: Writing 0 to bit 0 drives `attach_req` low and makes the configuration bytes writable again.
- R7: Writing 1 to bit 1 restores every configuration byte to its R1 value. The restore happens on the edge after the write is accepted. On that same edge bits 0, 1 and 2 return to 0, so bit 1 is set for exactly one cycle.
- R8: Writing 1 to bit 2 while bit 1 is 0 keeps `if_active` high until that write's response is taken. `if_active` drops on the edge where `rsp_valid` and `rsp_ready` are both high.
- R9: Once `if_active` is low, `req_ready` stays low and no response is produced until `rst_n` is asserted.
- R10: The response to a write carries `rsp_rdata` = 00h. The response to a read carries the byte as it stood on the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address; all ones selects the command byte |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Host takes the response (acknowledge complete) |
| rsp_rdata | output | 8 | Read data, 00h for writes |
| attach_req | output | 1 | Attach request toward the upstream side |
| if_active | output | 1 | Access port is powered |

## Verification
A response is due one edge after the accepting edge. The bench therefore samples it at the falling edge that follows acceptance and checks `rsp_valid` there. A soft reset takes effect one further edge later, which falls inside the response handshake. Because of that, the restored values and the cleared bits are checked with reads issued after the transfer ends. The power-down drop is tied to the response handshake edge. The bench holds `rsp_ready` low for several cycles and confirms that `if_active` stays high during that time. It then checks the port on the falling edge just after the single cycle in which `rsp_ready` is raised.

// File: rtl/cfg_regfile_pkg.sv
package cfg_regfile_pkg;
  localparam int BYTE_W = 8;

  localparam int CMD_ATTACH_BIT = 0;
  localparam int CMD_SRST_BIT   = 1;
  localparam int CMD_PDOWN_BIT  = 2;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic pdown;
    logic srst;
    logic attach;
  } cmd_state_t;

  function automatic byte_t cfg_default(int unsigned idx, byte_t base, byte_t step);
    int unsigned prod;
    prod = int'(base) + idx * int'(step);
    return byte_t'(prod);
  endfunction
endpackage

// File: rtl/cfg_access_ctrl.sv
module cfg_access_ctrl
  import cfg_regfile_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          srst_busy,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  byte_t         rd_byte,
  output logic          accept,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output byte_t         rsp_rdata,
  output logic          ack_done
);
  logic  pend_q;
  byte_t data_q;

  assign req_ready = active && !pend_q && !srst_busy;
  assign accept    = req_valid && req_ready;
  assign ack_done  = pend_q && rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (accept) begin
        pend_q <= 1'b1;
        data_q <= req_write ? '0 : rd_byte;
      end else if (ack_done) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign rsp_valid = pend_q;
  assign rsp_rdata = data_q;
endmodule

// File: rtl/cfg_byte_store.sv
module cfg_byte_store
  import cfg_regfile_pkg::*;
#(
  parameter int    AW       = 8,
  parameter byte_t DEF_BASE = 8'h11,
  parameter byte_t DEF_STEP = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          protect,
  input  logic          restore,
  input  logic [AW-1:0] addr,
  input  byte_t         wdata,
  output byte_t         rdata
);
  localparam int DEPTH = 1 << AW;
  localparam int CFG_N = DEPTH - 1;

  byte_t mem [CFG_N];

  for (genvar i = 0; i < CFG_N; i++) begin : g_byte
    localparam byte_t INIT = cfg_default(i, DEF_BASE, DEF_STEP);
    logic hit;
    assign hit = wr_en && !protect && (addr == AW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[i] <= INIT;
      end else if (restore) begin
        mem[i] <= INIT;
      end else if (hit) begin
        mem[i] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < CFG_N; k++) begin
      if (addr == AW'(k)) rdata = mem[k];
    end
  end
endmodule

// File: rtl/cfg_cmd_reg.sv
module cfg_cmd_reg
  import cfg_regfile_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  byte_t wdata,
  input  logic  ack_done,
  output byte_t status,
  output logic  attach,
  output logic  srst,
  output logic  active
);
  cmd_state_t st_q;
  logic       act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      act_q <= 1'b1;
    end else begin
      if (st_q.srst) begin
        st_q <= '0;
      end else if (wr_en) begin
        st_q.attach <= wdata[CMD_ATTACH_BIT];
        st_q.srst   <= wdata[CMD_SRST_BIT];
        st_q.pdown  <= wdata[CMD_PDOWN_BIT];
      end
      if (ack_done && st_q.pdown && !st_q.srst) begin
        act_q <= 1'b0;
      end
    end
  end

  always_comb begin
    status = '0;
    status[CMD_ATTACH_BIT] = st_q.attach;
    status[CMD_SRST_BIT]   = st_q.srst;
    status[CMD_PDOWN_BIT]  = st_q.pdown;
  end

  assign attach = st_q.attach;
  assign srst   = st_q.srst;
  assign active = act_q;
endmodule

// File: rtl/cfg_regfile_cmd.sv
module cfg_regfile_cmd
  import cfg_regfile_pkg::*;
#(
  parameter int    AW       = 8,
  parameter byte_t DEF_BASE = 8'h11,
  parameter byte_t DEF_STEP = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [7:0]    rsp_rdata,
  output logic          attach_req,
  output logic          if_active
);
  localparam logic [AW-1:0] CMD_ADDR = '1;

  logic  accept, ack_done, soft_rst, active;
  logic  sel_cmd, wr_cfg, wr_cmd;
  byte_t cfg_byte, cmd_byte, rd_byte;

  assign sel_cmd = (req_addr == CMD_ADDR);
  assign wr_cfg  = accept && req_write && !sel_cmd;
  assign wr_cmd  = accept && req_write && sel_cmd;
  assign rd_byte = sel_cmd ? cmd_byte : cfg_byte;

  cfg_access_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .active(active), .srst_busy(soft_rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .rd_byte(rd_byte), .accept(accept), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .ack_done(ack_done)
  );

  cfg_byte_store #(.AW(AW), .DEF_BASE(DEF_BASE), .DEF_STEP(DEF_STEP)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_cfg), .protect(attach_req),
    .restore(soft_rst), .addr(req_addr), .wdata(req_wdata), .rdata(cfg_byte)
  );

  cfg_cmd_reg u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_cmd), .wdata(req_wdata),
    .ack_done(ack_done), .status(cmd_byte), .attach(attach_req),
    .srst(soft_rst), .active(active)
  );

  assign if_active = active;
endmodule

// File: rtl/cfg_regfile_checker.sv
module cfg_regfile_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_rdata,
  input logic       attach_req,
  input logic       if_active,
  input logic       soft_rst
);
  assert_rsp_follows_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  assert_rsp_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_srst_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !soft_rst);

  assert_srst_clears_attach_R7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !attach_req);

  assert_pdown_at_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(if_active) |-> $past(rsp_valid && rsp_ready));

  assert_down_no_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !if_active |-> !req_ready);

  assert_down_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !if_active |=> !if_active);
endmodule

bind cfg_regfile_cmd cfg_regfile_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .attach_req(attach_req), .if_active(if_active), .soft_rst(soft_rst)
);

// File: tb/cfg_regfile_cmd_tb.sv
module cfg_regfile_cmd_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [7:0] req_addr = '0, req_wdata = '0;
  logic       req_ready, rsp_valid, attach_req, if_active;
  logic [7:0] rsp_rdata;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  cfg_regfile_cmd u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .attach_req(attach_req), .if_active(if_active)
  );

  function automatic logic [7:0] dflt(int unsigned a);
    return 8'((32'h11 + a * 32'h07) & 32'hFF);
  endfunction

  // {write, addr, wdata, expected rdata}
  function automatic logic [24:0] mk(logic w, logic [7:0] a, logic [7:0] d, logic [7:0] e);
    return {w, a, d, e};
  endfunction

  localparam int NV = 10;
  localparam logic [24:0] VEC [NV] = '{
    mk(1'b0, 8'h20, 8'h00, dflt(8'h20)),
    mk(1'b0, 8'h00, 8'h00, dflt(8'h00)),
    mk(1'b0, 8'hFE, 8'h00, dflt(8'hFE)),
    mk(1'b1, 8'h10, 8'hA5, 8'h00),
    mk(1'b0, 8'h10, 8'h00, 8'hA5),
    mk(1'b1, 8'hFE, 8'h3C, 8'h00),
    mk(1'b0, 8'hFE, 8'h00, 8'h3C),
    mk(1'b0, 8'hFF, 8'h00, 8'h00),
    mk(1'b1, 8'hFF, 8'hF8, 8'h00),
    mk(1'b0, 8'hFF, 8'h00, 8'h00)
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Issues one transfer with rsp_ready held high; returns response data.
  task automatic xfer(logic w, logic [7:0] a, logic [7:0] d, output logic [7:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    for (int t = 0; t < 20 && !req_ready; t++) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 rsp_valid after accept", {7'b0, rsp_valid}, 8'h01);
    r = rsp_rdata;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 attach_req", {7'b0, attach_req}, 8'h00);
    check("R1 if_active", {7'b0, if_active}, 8'h01);
    check("R1 req_ready", {7'b0, req_ready}, 8'h01);
    check("R1 rsp_valid", {7'b0, rsp_valid}, 8'h00);

    // Table walk: R1 defaults, R3 write/read, R4 reserved bits, R10 write data 0
    for (int i = 0; i < NV; i++) begin
      xfer(VEC[i][24], VEC[i][23:16], VEC[i][15:8], r);
      check($sformatf("R3/R4/R10 vector %0d", i), r, VEC[i][7:0]);
    end

    // R2 back-pressure
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h10;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check("R2 held valid", {7'b0, rsp_valid}, 8'h01);
      check("R2 held data", rsp_rdata, 8'hA5);
      check("R2 no ready while pending", {7'b0, req_ready}, 8'h00);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R2 response taken", {7'b0, rsp_valid}, 8'h00);

    // R5 attach and write protection
    xfer(1'b1, 8'hFF, 8'h01, r);
    check("R5 attach_req high", {7'b0, attach_req}, 8'h01);
    xfer(1'b0, 8'hFF, 8'h00, r);
    check("R4 status attach bit", r, 8'h01);
    xfer(1'b1, 8'h10, 8'h77, r);
    check("R5 protected write acked data", r, 8'h00);
    xfer(1'b0, 8'h10, 8'h00, r);
    check("R5 protected byte unchanged", r, 8'hA5);

    // R6 unlock
    xfer(1'b1, 8'hFF, 8'h00, r);
    check("R6 attach_req low", {7'b0, attach_req}, 8'h00);
    xfer(1'b1, 8'h10, 8'h77, r);
    xfer(1'b0, 8'h10, 8'h00, r);
    check("R6 write after unlock", r, 8'h77);

    // R7 soft reset with attach and power-down bits also set
    xfer(1'b1, 8'h30, 8'h99, r);
    xfer(1'b1, 8'hFF, 8'h07, r);
    check("R7 attach cleared", {7'b0, attach_req}, 8'h00);
    check("R7 still active", {7'b0, if_active}, 8'h01);
    xfer(1'b0, 8'hFF, 8'h00, r);
    check("R7 status cleared", r, 8'h00);
    xfer(1'b0, 8'h30, 8'h00, r);
    check("R7 byte 30h restored", r, dflt(8'h30));
    xfer(1'b0, 8'h10, 8'h00, r);
    check("R7 byte 10h restored", r, dflt(8'h10));
    xfer(1'b0, 8'hFE, 8'h00, r);
    check("R7 byte FEh restored", r, dflt(8'hFE));

    // R8 power-down waits for the acknowledge
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'hFF; req_wdata = 8'h04;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check("R8 active until ack", {7'b0, if_active}, 8'h01);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R8 down after ack", {7'b0, if_active}, 8'h00);
    check("R8 ready low", {7'b0, req_ready}, 8'h00);

    // R9 ignores requests while down
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h10; req_wdata = 8'h55;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R9 no ready", {7'b0, req_ready}, 8'h00);
      check("R9 no response", {7'b0, rsp_valid}, 8'h00);
    end
    req_valid = 1'b0;

    // R1 hardware reset brings everything back
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 active after reset", {7'b0, if_active}, 8'h01);
    xfer(1'b0, 8'h10, 8'h00, r);
    check("R1 byte 10h default", r, dflt(8'h10));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule